// File: doc/BRIEF.md
# Long-Mode Interrupt Entry Sequencer

This block steers a 64-bit core into an interrupt or trap handler. On a start pulse it captures the interrupt vector and the architectural state that the entry will change or save. That state is the instruction pointer, stack pointer, flags, the code and stack selectors and the current privilege level. It also captures the bases of the interrupt table and of the global and local descriptor tables. It then walks a fixed sequence over a single 64-bit memory port: two gate reads, one code-descriptor read, two probe accesses on the future stack frame, and five frame writes.

Every check is done before the first write. These checks are the gate type, the presence of the target code segment, the canonical form of the handler address, the stack-switch path and the frame probes. Any failure ends the sequence with a fault pulse, or with an unsupported pulse for stack switching, and no memory has been written. When the sequence succeeds, the block pulses `done_o` and presents the handler CS, RIP, RSP, SS and RFLAGS. The core then commits these values.

Top module: `irq_entry_seq`

## Requirements
- R1: The gate descriptor is fetched with two read operations (`mem_op_o` = 0) at `idt_base + vector*16` (low quadword) and then at that address + 8 (high quadword).
- R2: With gate type = low-quadword bits 43:40, a type where (type AND 0xE) differs from 0xE ends the sequence with `fault_o`, vector 13, error code 0.
- R3: The gate selector is low-quadword bits 31:16. The code descriptor is read from the local table base when selector bit 2 is set and from the global base otherwise, at base + (selector with bits 2:0 cleared).
- R4: A code descriptor with bit 47 (present) clear ends with `fault_o`, vector 11, error code = selector with bits 1:0 cleared.
- R5: The handler address is {high[31:0], low[63:48], low[15:0]}. If its bits 63:47 are neither all zeros nor all ones, the result is `fault_o`, vector 13, code 0.
- R6: A nonzero IST field (low bits 34:32) ends with `unsup_o` and `unsup_ist_o`=1. Otherwise, a nonzero value of (cpl − descriptor bits 46:45) mod 4 ends with `unsup_o` and `unsup_ist_o`=0. The checks run in the order R4, R5, R6.
- R7: The new stack pointer is (RSP − 40) with bits 3:0 cleared. Probe operations (`mem_op_o` = 1) go to new RSP + 0 and then + 32 before any write.
- R8: Five write operations (`mem_op_o` = 2) follow, at new RSP + 0, 8, 16, 24, 32, carrying old RIP, zero-extended old CS, old RFLAGS, old RSP and zero-extended old SS in that order.
- R9: On `done_o`, `new_cs_o` is the gate selector, `new_rip_o` the handler address, `new_rsp_o` the value of R7 and `new_ss_o` the old SS.
- R10: `new_rflags_o` is the old flags with bits 8, 14 and 16 cleared. Bit 9 is also cleared when gate type bit 0 is 0 and kept when it is 1.
- R11: Each sequence ends with exactly one one-cycle pulse of `done_o`, `fault_o` or `unsup_o`. An error response to a read or probe gives `fault_o` with vector 14 and code 0. A fault or unsupported ending issues no write.
- R12: Out of reset the block is idle with no request. A request that is not accepted stays asserted with unchanged operation, address and data. At most one access is outstanding, and the next request waits for the previous response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an entry sequence (taken when idle) |
| vector_i | input | 8 | Interrupt vector |
| rip_i | input | 64 | Instruction pointer to save |
| rsp_i | input | 64 | Current stack pointer |
| rflags_i | input | 64 | Current flags |
| cs_sel_i | input | 16 | Current code selector |
| ss_sel_i | input | 16 | Current stack selector |
| cpl_i | input | 2 | Current privilege level |
| idt_base_i | input | 64 | Interrupt table base |
| gdt_base_i | input | 64 | Global descriptor table base |
| ldt_base_i | input | 64 | Local descriptor table base |
| mem_req_o | output | 1 | Memory request valid |
| mem_op_o | output | 2 | 0 read, 1 probe, 2 write |
| mem_addr_o | output | 64 | Request address |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rsp_i | input | 1 | Response valid |
| mem_rdata_i | input | 64 | Read data |
| mem_err_i | input | 1 | Response reports an access fault |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Successful entry pulse |
| fault_o | output | 1 | Fault pulse |
| fault_vec_o | output | 8 | Fault vector |
| fault_code_o | output | 16 | Fault error code |
| unsup_o | output | 1 | Unsupported stack switch pulse |
| unsup_ist_o | output | 1 | Unsupported cause: 1 IST, 0 privilege change |
| new_cs_o | output | 16 | Handler code selector |
| new_rip_o | output | 64 | Handler address |
| new_rsp_o | output | 64 | Handler stack pointer |
| new_ss_o | output | 16 | Handler stack selector |
| new_rflags_o | output | 64 | Handler flags |

## Verification
The assertions assume that the memory side never raises `mem_rsp_i` unless an accepted request is outstanding. They also assume the response comes at least one cycle after acceptance, and that `start_i` is only pulsed while the block is idle. The bench responder models this exactly. It raises ready on a random subset of request cycles, answers after zero to two extra cycles, and the stimulus pulses start only once the previous ending pulse has been seen. Error responses are injected only on read and probe addresses, so the write phase never meets a fault.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int QW    = 64;
  localparam int SEL_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_GLO, S_GHI, S_GCHK, S_CSD, S_CCHK, S_PRB0, S_PRB1, S_WR
  } seq_state_t;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_PROBE = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;

  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_PF = 8'd14;

  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_NT = 14;
  localparam int FL_RF = 16;
  localparam int DESC_P = 47;
endpackage

// File: rtl/irq_gate_decode.sv
module irq_gate_decode
  import irq_entry_pkg::*;
(
  input  logic [QW-1:0]    gate_lo_i,
  input  logic [QW-1:0]    gate_hi_i,
  output logic             type_ok_o,
  output logic             trap_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             use_ldt_o,
  output logic [QW-1:0]    desc_off_o,
  output logic [2:0]       ist_o,
  output logic [QW-1:0]    target_o,
  output logic             canon_o
);
  logic [3:0] gate_type;

  assign gate_type  = gate_lo_i[43:40];
  assign type_ok_o  = (gate_type & 4'hE) == 4'hE;
  assign trap_o     = gate_type[0];
  assign sel_o      = gate_lo_i[31:16];
  assign use_ldt_o  = sel_o[2];
  assign desc_off_o = {{(QW-SEL_W){1'b0}}, sel_o[SEL_W-1:3], 3'b000};
  assign ist_o      = gate_lo_i[34:32];
  assign target_o   = {gate_hi_i[31:0], gate_lo_i[63:48], gate_lo_i[15:0]};
  assign canon_o    = (&target_o[63:47]) | ~(|target_o[63:47]);
endmodule

// File: rtl/irq_frame_calc.sv
module irq_frame_calc
  import irq_entry_pkg::*;
#(
  parameter int FRAME_QW = 5,
  parameter int IDX_W    = $clog2(FRAME_QW)
) (
  input  logic [QW-1:0]    rip_i,
  input  logic [QW-1:0]    rsp_i,
  input  logic [QW-1:0]    rflags_i,
  input  logic [SEL_W-1:0] cs_i,
  input  logic [SEL_W-1:0] ss_i,
  input  logic             trap_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [QW-1:0]    new_rsp_o,
  output logic [QW-1:0]    new_flags_o,
  output logic [QW-1:0]    probe_lo_o,
  output logic [QW-1:0]    probe_hi_o,
  output logic [QW-1:0]    wr_addr_o,
  output logic [QW-1:0]    wr_data_o
);
  localparam logic [QW-1:0] FRAME_BYTES = QW'(FRAME_QW * 8);

  logic [QW-1:0] slot_addr [FRAME_QW];
  logic [QW-1:0] slot_data [FRAME_QW];

  assign new_rsp_o = (rsp_i - FRAME_BYTES) & ~QW'(15);

  always_comb begin
    new_flags_o        = rflags_i;
    new_flags_o[FL_TF] = 1'b0;
    new_flags_o[FL_NT] = 1'b0;
    new_flags_o[FL_RF] = 1'b0;
    if (!trap_i) new_flags_o[FL_IF] = 1'b0;
  end

  for (genvar g = 0; g < FRAME_QW; g++) begin : g_slot
    assign slot_addr[g] = new_rsp_o + QW'(g * 8);
    if (g == 0) begin : g_rip
      assign slot_data[g] = rip_i;
    end else if (g == 1) begin : g_cs
      assign slot_data[g] = {{(QW-SEL_W){1'b0}}, cs_i};
    end else if (g == 2) begin : g_fl
      assign slot_data[g] = rflags_i;
    end else if (g == 3) begin : g_sp
      assign slot_data[g] = rsp_i;
    end else begin : g_ss
      assign slot_data[g] = {{(QW-SEL_W){1'b0}}, ss_i};
    end
  end

  assign probe_lo_o = slot_addr[0];
  assign probe_hi_o = slot_addr[FRAME_QW-1];
  assign wr_addr_o  = slot_addr[idx_i];
  assign wr_data_o  = slot_data[idx_i];
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int FRAME_QW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic [63:0]      rip_i,
  input  logic [63:0]      rsp_i,
  input  logic [63:0]      rflags_i,
  input  logic [15:0]      cs_sel_i,
  input  logic [15:0]      ss_sel_i,
  input  logic [1:0]       cpl_i,
  input  logic [63:0]      idt_base_i,
  input  logic [63:0]      gdt_base_i,
  input  logic [63:0]      ldt_base_i,
  output logic             mem_req_o,
  output logic [1:0]       mem_op_o,
  output logic [63:0]      mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic             mem_rsp_i,
  input  logic [63:0]      mem_rdata_i,
  input  logic             mem_err_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [7:0]       fault_vec_o,
  output logic [15:0]      fault_code_o,
  output logic             unsup_o,
  output logic             unsup_ist_o,
  output logic [15:0]      new_cs_o,
  output logic [63:0]      new_rip_o,
  output logic [63:0]      new_rsp_o,
  output logic [15:0]      new_ss_o,
  output logic [63:0]      new_rflags_o
);
  localparam int IDX_W = $clog2(FRAME_QW);

  seq_state_t state_q, state_d;
  logic pend_q, pend_d, wrote_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic done_q, fault_q, unsup_q;

  logic [VEC_W-1:0] vec_q;
  logic [QW-1:0] rip_q, rsp_q, fl_q, idt_q, gdt_q, ldt_q, glo_q, ghi_q, cdesc_q;
  logic [SEL_W-1:0] cs_q, ss_q;
  logic [1:0] cpl_q;

  logic type_ok, trap, use_ldt, canon;
  logic [SEL_W-1:0] gsel;
  logic [QW-1:0] desc_off, target, nrsp, nflags, probe_lo, probe_hi, wr_addr, wr_data;
  logic [2:0] ist;
  logic [QW-1:0] gate_addr, desc_addr;
  logic priv_chg, got, acc, rd_fault;
  logic fin_done, fin_fault, fin_unsup, fin_ist;
  logic [7:0] fin_vec;
  logic [15:0] fin_code;

  irq_gate_decode u_dec (
    .gate_lo_i(glo_q), .gate_hi_i(ghi_q), .type_ok_o(type_ok), .trap_o(trap),
    .sel_o(gsel), .use_ldt_o(use_ldt), .desc_off_o(desc_off), .ist_o(ist),
    .target_o(target), .canon_o(canon)
  );

  irq_frame_calc #(.FRAME_QW(FRAME_QW), .IDX_W(IDX_W)) u_frame (
    .rip_i(rip_q), .rsp_i(rsp_q), .rflags_i(fl_q), .cs_i(cs_q), .ss_i(ss_q),
    .trap_i(trap), .idx_i(idx_q), .new_rsp_o(nrsp), .new_flags_o(nflags),
    .probe_lo_o(probe_lo), .probe_hi_o(probe_hi), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  assign gate_addr = idt_q + (QW'(vec_q) << 4);
  assign desc_addr = (use_ldt ? ldt_q : gdt_q) + desc_off;
  assign priv_chg  = (cpl_q - cdesc_q[46:45]) != 2'd0;

  // Memory request drive: one access per memory state, dropped once accepted.
  always_comb begin
    mem_op_o    = OP_READ;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_GLO:  mem_addr_o = gate_addr;
      S_GHI:  mem_addr_o = gate_addr + QW'(8);
      S_CSD:  mem_addr_o = desc_addr;
      S_PRB0: begin mem_op_o = OP_PROBE; mem_addr_o = probe_lo; end
      S_PRB1: begin mem_op_o = OP_PROBE; mem_addr_o = probe_hi; end
      S_WR:   begin mem_op_o = OP_WRITE; mem_addr_o = wr_addr; mem_wdata_o = wr_data; end
      default: ;
    endcase
    mem_req_o = !pend_q && (state_q inside {S_GLO, S_GHI, S_CSD, S_PRB0, S_PRB1, S_WR});
  end

  assign acc      = mem_req_o && mem_ready_i;
  assign got      = pend_q && mem_rsp_i;
  assign rd_fault = got && mem_err_i && (state_q != S_WR);

  // Next-state logic
  always_comb begin
    state_d = state_q; pend_d = pend_q; idx_d = idx_q;
    fin_done = 1'b0; fin_fault = 1'b0; fin_unsup = 1'b0; fin_ist = 1'b0;
    fin_vec = '0; fin_code = '0;
    if (acc) pend_d = 1'b1;
    if (got) pend_d = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin state_d = S_GLO; idx_d = '0; end
      S_GLO:  if (got) state_d = S_GHI;
      S_GHI:  if (got) state_d = S_GCHK;
      S_GCHK: if (!type_ok) begin fin_fault = 1'b1; fin_vec = VEC_GP; end
              else state_d = S_CSD;
      S_CSD:  if (got) state_d = S_CCHK;
      S_CCHK: begin
        if (!cdesc_q[DESC_P]) begin
          fin_fault = 1'b1; fin_vec = VEC_NP; fin_code = {gsel[15:2], 2'b00};
        end else if (!canon) begin
          fin_fault = 1'b1; fin_vec = VEC_GP;
        end else if (ist != 3'd0) begin
          fin_unsup = 1'b1; fin_ist = 1'b1;
        end else if (priv_chg) begin
          fin_unsup = 1'b1;
        end else begin
          state_d = S_PRB0;
        end
      end
      S_PRB0: if (got) state_d = S_PRB1;
      S_PRB1: if (got) state_d = S_WR;
      S_WR: if (got) begin
        if (idx_q == IDX_W'(FRAME_QW - 1)) fin_done = 1'b1;
        else idx_d = idx_q + 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    if (rd_fault) begin fin_fault = 1'b1; fin_vec = VEC_PF; fin_code = '0; end
    if (fin_done || fin_fault || fin_unsup) state_d = S_IDLE;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; pend_q <= 1'b0; idx_q <= '0; wrote_q <= 1'b0;
      done_q <= 1'b0; fault_q <= 1'b0; unsup_q <= 1'b0;
    end else begin
      state_q <= state_d; pend_q <= pend_d; idx_q <= idx_d;
      done_q <= fin_done; fault_q <= fin_fault; unsup_q <= fin_unsup;
      if (state_q == S_IDLE && start_i) wrote_q <= 1'b0;
      else if (acc && state_q == S_WR) wrote_q <= 1'b1;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (state_q == S_IDLE && start_i) begin
      vec_q <= vector_i; rip_q <= rip_i; rsp_q <= rsp_i; fl_q <= rflags_i;
      cs_q <= cs_sel_i; ss_q <= ss_sel_i; cpl_q <= cpl_i;
      idt_q <= idt_base_i; gdt_q <= gdt_base_i; ldt_q <= ldt_base_i;
    end
    if (got && state_q == S_GLO) glo_q   <= mem_rdata_i;
    if (got && state_q == S_GHI) ghi_q   <= mem_rdata_i;
    if (got && state_q == S_CSD) cdesc_q <= mem_rdata_i;
    if (fin_done) begin
      new_cs_o <= gsel; new_rip_o <= target; new_rsp_o <= nrsp;
      new_ss_o <= ss_q; new_rflags_o <= nflags;
    end
    if (fin_fault) begin fault_vec_o <= fin_vec; fault_code_o <= fin_code; end
    if (fin_unsup) unsup_ist_o <= fin_ist;
  end

  assign busy_o  = state_q != S_IDLE;
  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign unsup_o = unsup_q;

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_op_o) && $stable(mem_wdata_o)));

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, unsup_o}));

  a_r11_no_write_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o || unsup_o) |-> !wrote_q);

  a_r7_rsp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (new_rsp_o[3:0] == 4'd0));

  a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!new_rflags_o[FL_TF] && !new_rflags_o[FL_NT] && !new_rflags_o[FL_RF]));

  a_r12_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o || unsup_o) |-> !busy_o);
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start_i;
  logic [7:0] vector_i;
  logic [63:0] rip_i, rsp_i, rflags_i, idt_base_i, gdt_base_i, ldt_base_i;
  logic [15:0] cs_sel_i, ss_sel_i;
  logic [1:0] cpl_i;
  logic mem_req_o, mem_ready_i, mem_rsp_i, mem_err_i;
  logic [1:0] mem_op_o;
  logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic busy_o, done_o, fault_o, unsup_o, unsup_ist_o;
  logic [7:0] fault_vec_o;
  logic [15:0] fault_code_o, new_cs_o, new_ss_o;
  logic [63:0] new_rip_o, new_rsp_o, new_rflags_o;

  irq_entry_seq u_irq_entry_seq (.*);

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic [63:0] mem [logic [63:0]];

  logic [7:0]  c_vec;
  logic [63:0] c_rip, c_rsp, c_fl, c_idt, c_gdt, c_ldt, c_off, c_cd, c_glo, c_ghi;
  logic [15:0] c_cs, c_ss, c_sel;
  logic [1:0]  c_cpl, c_dpl;
  logic [3:0]  c_type;
  logic [2:0]  c_ist;
  logic        c_pres, err_en;
  logic [63:0] err_addr;

  logic [1:0]  lop [16];
  logic [63:0] laddr [16], ldata [16];
  int lcnt;

  logic [1:0]  eop [16];
  logic [63:0] eaddr [16], edata [16];
  string etag [16];
  int ecnt;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                     input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory responder: random acceptance, response 1..3 cycles after acceptance.
  logic waiting = 1'b0, stall_prev = 1'b0, r_err;
  int lat;
  logic [63:0] r_data, stall_addr;
  logic [1:0] stall_op;
  always @(negedge clk) begin
    mem_rsp_i = 1'b0; mem_err_i = 1'b0; mem_ready_i = 1'b0;
    if (!rst_n) begin
      waiting = 1'b0; stall_prev = 1'b0;
    end else begin
      if (stall_prev) begin
        chk("R12", {mem_req_o, mem_op_o, mem_addr_o[60:0]},
            {1'b1, stall_op, stall_addr[60:0]}, "stalled request held");
        stall_prev = 1'b0;
      end
      if (waiting) begin
        if (lat == 0) begin
          mem_rsp_i = 1'b1; mem_rdata_i = r_data; mem_err_i = r_err; waiting = 1'b0;
        end else lat--;
      end else if (mem_req_o) begin
        if ($urandom % 4 != 0) begin
          mem_ready_i = 1'b1;
          if (lcnt < 16) begin
            lop[lcnt] = mem_op_o; laddr[lcnt] = mem_addr_o; ldata[lcnt] = mem_wdata_o;
          end
          lcnt++;
          r_data = (mem_op_o != 2'd2 && mem.exists(mem_addr_o)) ? mem[mem_addr_o] : 64'h0;
          r_err  = err_en && mem_addr_o == err_addr && mem_op_o != 2'd2;
          waiting = 1'b1;
          lat = int'($urandom % 3);
        end else begin
          stall_prev = 1'b1; stall_addr = mem_addr_o; stall_op = mem_op_o;
        end
      end
    end
  end

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic set_base();
    logic [63:0] r;
    c_vec = 8'($urandom); c_rip = rnd64(); c_rsp = rnd64(); c_fl = rnd64();
    c_cs = 16'($urandom); c_ss = 16'($urandom); c_cpl = 2'($urandom); c_dpl = c_cpl;
    c_type = 4'hE | 4'($urandom % 2); c_ist = 3'd0; c_pres = 1'b1;
    c_sel = 16'($urandom);
    r = rnd64();
    c_off = r[47] ? {17'h1FFFF, r[46:0]} : {17'h0, r[46:0]};
    c_idt = 64'h1000_0000 + 64'(($urandom % 16) * 4096);
    c_gdt = 64'h2000_0000; c_ldt = 64'h3000_0000;
    err_en = 1'b0; err_addr = '0;
  endtask

  task automatic add_exp(input logic [1:0] op, input logic [63:0] a, input logic [63:0] d,
                         input string tag);
    eop[ecnt] = op; eaddr[ecnt] = a; edata[ecnt] = d; etag[ecnt] = tag; ecnt++;
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Build memory, compute the expected outcome, run one entry and compare.
  task automatic run_case(input string name);
    logic [63:0] ga, da, nr, tgt, efl;
    int ekind; logic [7:0] evec; logic [15:0] ecode; logic eist;
    string ktag;
    bit hit; int k;
    mem.delete();
    ga = c_idt + ({56'h0, c_vec} << 4);
    c_glo = {c_off[31:16], 1'b1, 2'b00, 1'b0, c_type, 5'b0, c_ist, c_sel, c_off[15:0]};
    c_ghi = {32'h0, c_off[63:32]};
    c_cd = rnd64(); c_cd[47] = c_pres; c_cd[46:45] = c_dpl;
    da = (c_sel[2] ? c_ldt : c_gdt) + {48'h0, c_sel[15:3], 3'b000};
    mem[ga] = c_glo; mem[ga + 64'd8] = c_ghi; mem[da] = c_cd;
    nr = (c_rsp - 64'd40) & ~64'hF;
    tgt = {c_ghi[31:0], c_glo[63:48], c_glo[15:0]};
    efl = c_fl & ~64'h14100;
    if (!c_type[0]) efl[9] = 1'b0;

    ecnt = 0; ekind = 0; evec = '0; ecode = '0; eist = 1'b0; ktag = "R9";
    begin : model
      add_exp(2'd0, ga, 64'h0, "R1");
      if (err_en && err_addr == ga) begin ekind = 1; evec = 8'd14; ktag = "R11"; disable model; end
      add_exp(2'd0, ga + 64'd8, 64'h0, "R1");
      if (err_en && err_addr == ga + 64'd8) begin ekind = 1; evec = 8'd14; ktag = "R11"; disable model; end
      if ((c_type & 4'hE) != 4'hE) begin ekind = 1; evec = 8'd13; ktag = "R2"; disable model; end
      add_exp(2'd0, da, 64'h0, "R3");
      if (err_en && err_addr == da) begin ekind = 1; evec = 8'd14; ktag = "R11"; disable model; end
      if (!c_pres) begin ekind = 1; evec = 8'd11; ecode = {c_sel[15:2], 2'b00}; ktag = "R4"; disable model; end
      if (!(&tgt[63:47] || !(|tgt[63:47]))) begin ekind = 1; evec = 8'd13; ktag = "R5"; disable model; end
      if (c_ist != 3'd0) begin ekind = 2; eist = 1'b1; ktag = "R6"; disable model; end
      if (2'(c_cpl - c_dpl) != 2'd0) begin ekind = 2; eist = 1'b0; ktag = "R6"; disable model; end
      add_exp(2'd1, nr, 64'h0, "R7");
      if (err_en && err_addr == nr) begin ekind = 1; evec = 8'd14; ktag = "R11"; disable model; end
      add_exp(2'd1, nr + 64'd32, 64'h0, "R7");
      if (err_en && err_addr == nr + 64'd32) begin ekind = 1; evec = 8'd14; ktag = "R11"; disable model; end
      add_exp(2'd2, nr, c_rip, "R8");
      add_exp(2'd2, nr + 64'd8, {48'h0, c_cs}, "R8");
      add_exp(2'd2, nr + 64'd16, c_fl, "R8");
      add_exp(2'd2, nr + 64'd24, c_rsp, "R8");
      add_exp(2'd2, nr + 64'd32, {48'h0, c_ss}, "R8");
    end

    @(negedge clk);
    lcnt = 0;
    vector_i = c_vec; rip_i = c_rip; rsp_i = c_rsp; rflags_i = c_fl;
    cs_sel_i = c_cs; ss_sel_i = c_ss; cpl_i = c_cpl;
    idt_base_i = c_idt; gdt_base_i = c_gdt; ldt_base_i = c_ldt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    hit = 0;
    for (int i = 0; i < 400; i++) begin
      if (done_o || fault_o || unsup_o) begin hit = 1; break; end
      @(negedge clk);
    end
    if (!hit) begin
      nchk++; nerr++;
      $display("FAIL R11 %s no ending pulse actual=none expected=kind%0d", name, ekind);
      reset_dut();
      return;
    end
    k = done_o ? 0 : (fault_o ? 1 : 2);
    chk(ktag, 64'(k), 64'(ekind), {name, " outcome kind"});
    if (ekind == 1 && k == 1) begin
      chk(ktag, {56'h0, fault_vec_o}, {56'h0, evec}, {name, " fault vector"});
      chk(ktag, {48'h0, fault_code_o}, {48'h0, ecode}, {name, " fault code"});
    end
    if (ekind == 2 && k == 2)
      chk("R6", {63'h0, unsup_ist_o}, {63'h0, eist}, {name, " unsupported cause"});
    if (ekind == 0 && k == 0) begin
      chk("R9",  {48'h0, new_cs_o}, {48'h0, c_sel}, {name, " new CS"});
      chk("R9",  new_rip_o, tgt, {name, " new RIP"});
      chk("R7",  new_rsp_o, nr, {name, " new RSP"});
      chk("R9",  {48'h0, new_ss_o}, {48'h0, c_ss}, {name, " new SS"});
      chk("R10", new_rflags_o, efl, {name, " new RFLAGS"});
    end
    chk(ekind == 0 ? "R8" : "R11", 64'(lcnt), 64'(ecnt), {name, " access count"});
    for (int i = 0; i < ecnt && i < lcnt && i < 16; i++) begin
      chk(etag[i], {62'h0, lop[i]}, {62'h0, eop[i]}, {name, " access op"});
      chk(etag[i], laddr[i], eaddr[i], {name, " access address"});
      if (eop[i] == 2'd2) chk(etag[i], ldata[i], edata[i], {name, " write data"});
    end
    chk("R11", {63'h0, busy_o}, 64'h0, {name, " idle after end"});
  endtask

  task automatic run_random(input int n);
    logic [63:0] ga, da, nr;
    int pick;
    set_base();
    if ($urandom % 6 == 0) c_type = 4'($urandom);
    if ($urandom % 10 == 0) c_pres = 1'b0;
    if ($urandom % 8 == 0) c_off[63:47] = 17'h0A5A5;
    if ($urandom % 8 == 0) c_ist = 3'($urandom);
    if ($urandom % 6 == 0) c_dpl = 2'($urandom);
    if ($urandom % 8 == 0) begin
      ga = c_idt + ({56'h0, c_vec} << 4);
      da = (c_sel[2] ? c_ldt : c_gdt) + {48'h0, c_sel[15:3], 3'b000};
      nr = (c_rsp - 64'd40) & ~64'hF;
      pick = int'($urandom % 5);
      err_en = 1'b1;
      err_addr = (pick == 0) ? ga : (pick == 1) ? ga + 64'd8 : (pick == 2) ? da :
                 (pick == 3) ? nr : nr + 64'd32;
    end
    run_case($sformatf("random%0d", n));
  endtask

  initial begin
    void'($urandom(32'd2024));
    vector_i = '0; rip_i = '0; rsp_i = '0; rflags_i = '0; cs_sel_i = '0; ss_sel_i = '0;
    cpl_i = '0; idt_base_i = '0; gdt_base_i = '0; ldt_base_i = '0; mem_rdata_i = '0;
    lcnt = 0; err_en = 1'b0; err_addr = '0;
    reset_dut();
    chk("R12", {63'h0, busy_o}, 64'h0, "reset busy");
    chk("R12", {63'h0, mem_req_o}, 64'h0, "reset request");
    chk("R11", {61'h0, done_o, fault_o, unsup_o}, 64'h0, "reset pulses");

    set_base(); c_type = 4'hE; c_sel[2] = 1'b0; c_rsp = 64'h0000_7FFF_0000_1000;
    run_case("interrupt gate global table R1");
    set_base(); c_type = 4'hF; c_sel[2] = 1'b1; c_rsp = 64'h0000_7FFF_0000_1237;
    c_fl = '1; run_case("trap gate local table R3 R10");
    set_base(); c_type = 4'hC; run_case("bad type R2");
    set_base(); c_type = 4'h6; run_case("bad type low R2");
    set_base(); c_pres = 1'b0; c_sel = 16'hABCF; run_case("not present R4");
    set_base(); c_off = 64'h0001_0000_0000_0000; run_case("noncanonical R5");
    set_base(); c_off = 64'hFFFF_8000_0000_0000; run_case("canonical edge R5");
    set_base(); c_ist = 3'd3; c_dpl = c_cpl + 2'd1; run_case("ist over privilege R6");
    set_base(); c_cpl = 2'd3; c_dpl = 2'd0; run_case("privilege change R6");
    set_base(); err_en = 1'b1; err_addr = c_idt + ({56'h0, c_vec} << 4) + 64'd8;
    run_case("gate read error R11");
    set_base(); err_en = 1'b1; err_addr = ((c_rsp - 64'd40) & ~64'hF) + 64'd32;
    run_case("probe error R11");
    set_base(); c_vec = 8'hFF; c_fl = '1; c_type = 4'hE; run_case("vector 255 flags R10");
    set_base(); c_rsp = 64'h0000_0000_0000_0028; run_case("stack wrap low R7");

    for (int n = 0; n < 40; n++) run_random(n);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule